// File: doc/BRIEF.md
# Stream Configuration Packet Router

The block sits behind a write-only stream window. Software pushes 32-bit words into it, and address bits [3:2] of each write pick one of four word slots. Writing the last slot completes a 128-bit quadword. The block then decodes a header held in the first word and routes the quadword to a set of row ports.

Two kinds of header are acted on. A local header that names the frame-data register arms a burst: it loads a quadword count and latches a target row. The quadwords that follow are passed on whole, with no header decoding, until the count runs out. A row header sends a register packet to one row. It carries the register address from the header and the three payload words that follow. A reserved row code reaches every row port that is present.

A decompress control input holds the block idle: while it is set, completed quadwords are discarded. The remaining burst count can be read at any time. A count that is not a whole number of frames raises a one-cycle error pulse, and the count is still used.

Top module: `stream_pkt_router`

## Requirements
- R1: Each accepted write (`wr_en`=1) stores `wr_data` in slot `wr_addr[3:2]`. Slot 0 becomes bits [31:0] of the quadword and slot 3 becomes bits [127:96]. Slots may be written in any order.
- R2: A write to slot 3 completes the quadword and clears all four slots to zero. A slot not written since the last completion contributes zero.
- R3: Header fields are taken from word 0 only: packet type in bits [31:24], row in bits [20:16], register address in bits [13:8]. All other bits of word 0 are ignored when decoding.
- R4: While `decomp_en`=1, a completed quadword produces no output pulse and leaves `burst_left` unchanged.
- R5: While `burst_left` is nonzero, a completed quadword is forwarded whatever its header says. It goes to the latched row with `out_reg` equal to the frame-data register address (default 6'h02) and `out_data` equal to all four words. `burst_left` then falls by one.
- R6: With `burst_left` zero, a header of local type (default 8'hC1) whose register address equals the frame-data address loads word 1 into `burst_left`. Its row field is latched as the burst target, and no packet is sent.
- R7: When a load value is not a multiple of 25 (default), `cnt_err` pulses high for one cycle, and the value is loaded anyway.
- R8: With `burst_left` zero, a header of row type (default 8'hA2) sends a packet to the row named in the header. `out_reg` is the header's register address, `out_data[95:0]` holds words 3..1 (word 1 lowest), and `out_data[127:96]` is zero.
- R9: Row code 5'h1F is a broadcast. The packet reaches every row whose `row_present` bit is set.
- R10: A packet only ever reaches a row whose `row_present` bit was set in the completing cycle. Packets for absent rows, and for row codes 15 to 30, are dropped.
- R11: With `burst_left` zero, a header whose type matches neither code is ignored. So is a local-type header that names any other register. Neither produces output or a count change.
- R12: While `rst_n`=0 the slots, `burst_left`, the latched row, `out_valid` and `cnt_err` clear to zero.
- R13: `out_valid` is a one-cycle pulse that is registered in the cycle after the completing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Stream write strobe |
| wr_addr | input | 2 | Write address bits [3:2], the slot index |
| wr_data | input | 32 | Write data |
| decomp_en | input | 1 | Decompress control; 1 discards completed quadwords |
| row_present | input | 15 | One bit per row port that exists |
| out_valid | output | 15 | One-cycle packet strobe per row |
| out_reg | output | 6 | Register address of the packet |
| out_data | output | 128 | Packet payload |
| burst_left | output | 32 | Remaining frame-data quadwords |
| cnt_err | output | 1 | Pulse: loaded count not a multiple of 25 |

## Verification
A stale slot, a wrong count or a wrong latched row shows on the very next quadword completion. It appears as a payload with leftover words, a strobe on the wrong row, or a `burst_left` value that is off by one, and all of these are visible one cycle after the slot-3 write. The bench therefore predicts every completion in full: the strobe pattern, the register address, the payload, the count and the error flag. It also treats any strobe it did not predict as an error. This catches both lost and spurious packets during bursts, broadcasts and reset.

// File: rtl/stream_router_pkg.sv
// Shared sizes and header helpers for the stream packet router.
// Assumes 32-bit words and a header laid out in word 0 of each quadword.
package stream_router_pkg;
    localparam int WORD_W = 32;
    localparam int ROW_W  = 5;
    localparam int REG_W  = 6;
    localparam int QW_W   = 4 * WORD_W;

    typedef struct packed {
        logic [7:0]       ptype;
        logic [ROW_W-1:0] row;
        logic [REG_W-1:0] reg_addr;
    } hdr_t;

    // Pull the header fields out of word 0.
    function automatic hdr_t hdr_of(input logic [WORD_W-1:0] w0);
        hdr_t h;
        h.ptype    = w0[31:24];
        h.row      = w0[20:16];
        h.reg_addr = w0[13:8];
        return h;
    endfunction
endpackage

// File: rtl/qword_assembler.sv
// Four-slot word buffer. It captures stream writes by slot index and releases a
// quadword, combinationally, in the cycle of the slot-3 write. All
// slots then clear to zero. Assumes one write per cycle at most.
module qword_assembler
    import stream_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        slot,
    input  logic [WORD_W-1:0] wr_data,
    output logic              qw_valid,
    output logic [QW_W-1:0]   qw
);
    localparam int NSLOT = 4;
    localparam logic [1:0] LAST = 2'(NSLOT - 1);

    logic [WORD_W-1:0] slot_q [NSLOT-1];

    assign qw_valid = wr_en && (slot == LAST);

    genvar i;
    generate
        for (i = 0; i < NSLOT - 1; i++) begin : g_slot
            // Hold one word; clear on reset or on completion.
            always_ff @(posedge clk) begin
                if (!rst_n || qw_valid) begin
                    slot_q[i] <= '0;
                end else if (wr_en && slot == 2'(i)) begin
                    slot_q[i] <= wr_data;
                end
            end
            assign qw[i*WORD_W +: WORD_W] = slot_q[i];
        end
    endgenerate

    assign qw[LAST*WORD_W +: WORD_W] = wr_data;
endmodule

// File: rtl/burst_sequencer.sv
// Decodes completed quadwords. It keeps the frame-data burst count and the
// latched target row, and asks for a forward (row, register, payload)
// in the same cycle. Assumes the caller registers the forward request.
module burst_sequencer
    import stream_router_pkg::*;
#(
    parameter logic [7:0]       PT_LOCAL   = 8'hC1,
    parameter logic [7:0]       PT_ROW     = 8'hA2,
    parameter logic [REG_W-1:0] FDATA_REG  = 6'h02,
    parameter int               BURST_MULT = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qw_valid,
    input  logic [QW_W-1:0]   qw,
    input  logic              decomp_en,
    output logic              fwd,
    output logic [ROW_W-1:0]  fwd_row,
    output logic [REG_W-1:0]  fwd_reg,
    output logic [QW_W-1:0]   fwd_data,
    output logic [WORD_W-1:0] burst_left,
    output logic              cnt_err
);
    logic [WORD_W-1:0] w0, w1, w2, w3;
    hdr_t              hdr;
    logic [ROW_W-1:0]  burst_row;
    logic              take, in_burst, do_load;

    assign {w3, w2, w1, w0} = qw;
    assign hdr      = hdr_of(w0);
    assign take     = qw_valid && !decomp_en;
    assign in_burst = (burst_left != '0);

    // Choose between burst data, count load, row packet or nothing.
    always_comb begin
        fwd      = 1'b0;
        do_load  = 1'b0;
        fwd_row  = hdr.row;
        fwd_reg  = hdr.reg_addr;
        fwd_data = {{WORD_W{1'b0}}, w3, w2, w1};
        if (take) begin
            if (in_burst) begin
                fwd      = 1'b1;
                fwd_row  = burst_row;
                fwd_reg  = FDATA_REG;
                fwd_data = qw;
            end else if (hdr.ptype == PT_LOCAL && hdr.reg_addr == FDATA_REG) begin
                do_load = 1'b1;
            end else if (hdr.ptype == PT_ROW) begin
                fwd = 1'b1;
            end
        end
    end

    // Burst count, target row and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_left <= '0;
            burst_row  <= '0;
            cnt_err    <= 1'b0;
        end else begin
            cnt_err <= do_load && ((w1 % WORD_W'(BURST_MULT)) != '0);
            if (do_load) begin
                burst_left <= w1;
                burst_row  <= hdr.row;
            end else if (take && in_burst) begin
                burst_left <= burst_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/row_fanout.sv
// Turns a target row code into a per-row strobe mask. The broadcast code
// selects every present row, and a code with no matching row selects none.
module row_fanout
    import stream_router_pkg::*;
#(
    parameter int               NROWS = 15,
    parameter logic [ROW_W-1:0] BCAST = 5'h1F
) (
    input  logic             fwd,
    input  logic [ROW_W-1:0] row,
    input  logic [NROWS-1:0] present,
    output logic [NROWS-1:0] mask
);
    genvar i;
    generate
        for (i = 0; i < NROWS; i++) begin : g_row
            // One row: selected by its own code or by broadcast.
            assign mask[i] = fwd && present[i] &&
                             ((row == BCAST) || (row == ROW_W'(i)));
        end
    endgenerate
endmodule

// File: rtl/stream_pkt_router.sv
// Top level: stream window to row-port packet router. It chains the assembler,
// the sequencer and the fan-out, and registers the packet outputs so
// that each forward is a one-cycle strobe.
module stream_pkt_router
    import stream_router_pkg::*;
#(
    parameter int               NROWS      = 15,
    parameter logic [7:0]       PT_LOCAL   = 8'hC1,
    parameter logic [7:0]       PT_ROW     = 8'hA2,
    parameter logic [REG_W-1:0] FDATA_REG  = 6'h02,
    parameter logic [ROW_W-1:0] BCAST      = 5'h1F,
    parameter int               BURST_MULT = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:2]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              decomp_en,
    input  logic [NROWS-1:0]  row_present,
    output logic [NROWS-1:0]  out_valid,
    output logic [REG_W-1:0]  out_reg,
    output logic [QW_W-1:0]   out_data,
    output logic [WORD_W-1:0] burst_left,
    output logic              cnt_err
);
    logic             qw_valid, fwd;
    logic [QW_W-1:0]  qw, fwd_data;
    logic [ROW_W-1:0] fwd_row;
    logic [REG_W-1:0] fwd_reg;
    logic [NROWS-1:0] mask;

    qword_assembler u_asm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .slot(wr_addr),
        .wr_data(wr_data), .qw_valid(qw_valid), .qw(qw)
    );

    burst_sequencer #(
        .PT_LOCAL(PT_LOCAL), .PT_ROW(PT_ROW),
        .FDATA_REG(FDATA_REG), .BURST_MULT(BURST_MULT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .qw_valid(qw_valid), .qw(qw),
        .decomp_en(decomp_en), .fwd(fwd), .fwd_row(fwd_row),
        .fwd_reg(fwd_reg), .fwd_data(fwd_data),
        .burst_left(burst_left), .cnt_err(cnt_err)
    );

    row_fanout #(.NROWS(NROWS), .BCAST(BCAST)) u_fan (
        .fwd(fwd), .row(fwd_row), .present(row_present), .mask(mask)
    );

    // Register the strobe mask and the packet contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_reg   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= mask;
            if (fwd) begin
                out_reg  <= fwd_reg;
                out_data <= fwd_data;
            end
        end
    end
endmodule

// File: rtl/stream_router_chk.sv
// Property checker for stream_pkt_router, attached by bind below.
module stream_router_chk #(
    parameter int NROWS      = 15,
    parameter int CNT_W      = 32,
    parameter int BURST_MULT = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             decomp_en,
    input logic [NROWS-1:0] row_present,
    input logic [NROWS-1:0] out_valid,
    input logic [CNT_W-1:0] burst_left,
    input logic             cnt_err
);
    // R13: a strobe always follows a slot-3 write
    a_r13_strobe_follows_completion: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> $past(wr_en && wr_addr == 2'd3));

    // R10: never strobe a row that was absent
    a_r10_present_rows_only: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & ~$past(row_present)) == '0);

    // R4: decompress mode discards quadwords
    a_r4_decomp_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $past(decomp_en) |-> (out_valid == '0 && burst_left == $past(burst_left)));

    // R5: a running count only steps down by one
    a_r5_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(burst_left) != '0 && burst_left != $past(burst_left))
        |-> burst_left == $past(burst_left) - 1'b1);

    // R7: error flag only beside a non-multiple count
    a_r7_err_nonmultiple: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_err |-> (burst_left % CNT_W'(BURST_MULT)) != '0);
endmodule

bind stream_pkt_router stream_router_chk #(
    .NROWS(NROWS), .CNT_W(32), .BURST_MULT(BURST_MULT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .decomp_en(decomp_en), .row_present(row_present), .out_valid(out_valid),
    .burst_left(burst_left), .cnt_err(cnt_err)
);

// File: tb/sim_stream_pkt_router.sv
module sim_stream_pkt_router;
    localparam int NR = 15;
    localparam logic [7:0] LOC = 8'hC1, ROWT = 8'hA2;
    localparam logic [5:0] FREG = 6'h02;

    logic          clk = 0, rst_n = 0, wr_en = 0, decomp_en = 0;
    logic [1:0]    wr_addr = 0;
    logic [31:0]   wr_data = 0;
    logic [NR-1:0] row_present = '1;
    logic [NR-1:0] out_valid;
    logic [5:0]    out_reg;
    logic [127:0]  out_data;
    logic [31:0]   burst_left;
    logic          cnt_err;

    stream_pkt_router u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .decomp_en(decomp_en), .row_present(row_present),
        .out_valid(out_valid), .out_reg(out_reg), .out_data(out_data),
        .burst_left(burst_left), .cnt_err(cnt_err)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [NR-1:0] mask;
        logic [5:0]    regv;
        logic [127:0]  data;
        logic [31:0]   cnt;
        logic          err;
        string         tag;
    } item_t;

    item_t exp_q[$];
    item_t held;
    bit    armed = 0;
    int    n_chk = 0, n_bad = 0;

    logic [31:0]   m_buf [4];
    logic [31:0]   m_cnt = 0;
    logic [4:0]    m_row = 0;
    logic          m_decomp = 0;
    logic [NR-1:0] m_present = '1;

    function automatic logic [NR-1:0] mask_for(input logic [4:0] r);
        if (r == 5'h1F) return m_present;
        if (r < 5'd15) return m_present & (NR'(1) << r);
        return '0;
    endfunction

    // Header with junk in the ignored bits (R3)
    function automatic logic [31:0] hdr(input logic [7:0] t, input logic [4:0] r,
                                        input logic [5:0] g);
        return {t, 3'b101, r, 2'b11, g, 8'h5A};
    endfunction

    // Monitor: compare each completion one cycle after it, flag stray strobes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (armed) begin
                n_chk++;
                if (out_valid !== held.mask || burst_left !== held.cnt || cnt_err !== held.err ||
                    (held.mask != '0 && (out_reg !== held.regv || out_data !== held.data))) begin
                    n_bad++;
                    $display("FAIL %s: valid=%h reg=%h data=%h cnt=%0d err=%b exp valid=%h reg=%h data=%h cnt=%0d err=%b",
                             held.tag, out_valid, out_reg, out_data, burst_left, cnt_err,
                             held.mask, held.regv, held.data, held.cnt, held.err);
                end
                armed = 0;
            end else if (out_valid != '0) begin
                n_chk++; n_bad++;
                $display("FAIL R13: unexpected strobe valid=%h expected 0", out_valid);
            end
            if (exp_q.size() != 0) begin
                held  = exp_q.pop_front();
                armed = 1;
            end
        end
    end

    // Driver: one stream write, with the expected result queued on completion.
    task automatic wr(input logic [1:0] s, input logic [31:0] d, input string tag);
        item_t e;
        @(posedge clk); #2;
        wr_en = 1; wr_addr = s; wr_data = d;
        decomp_en = m_decomp; row_present = m_present;
        m_buf[s] = d;
        if (s == 2'd3) begin
            e.mask = '0; e.regv = '0; e.data = '0; e.err = 0; e.tag = tag;
            if (!m_decomp) begin
                if (m_cnt != 0) begin
                    e.mask = mask_for(m_row); e.regv = FREG;
                    e.data = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
                    m_cnt--;
                end else if (m_buf[0][31:24] == LOC && m_buf[0][13:8] == FREG) begin
                    m_cnt = m_buf[1]; m_row = m_buf[0][20:16];
                    e.err = (m_buf[1] % 25) != 0;
                end else if (m_buf[0][31:24] == ROWT) begin
                    e.mask = mask_for(m_buf[0][20:16]); e.regv = m_buf[0][13:8];
                    e.data = {32'h0, m_buf[3], m_buf[2], m_buf[1]};
                end
            end
            e.cnt = m_cnt;
            exp_q.push_back(e);
            foreach (m_buf[k]) m_buf[k] = '0;
        end
    endtask

    task automatic idle(input int n);
        @(posedge clk); #2; wr_en = 0;
        repeat (n) @(posedge clk);
    endtask

    task automatic quad(input logic [31:0] a, b, c, d, input string tag);
        wr(0, a, tag); wr(1, b, tag); wr(2, c, tag); wr(3, d, tag);
    endtask

    task automatic check_reset(input string tag);
        @(negedge clk);
        n_chk++;
        if (out_valid !== '0 || burst_left !== 0 || cnt_err !== 0) begin
            n_bad++;
            $display("FAIL %s: valid=%h cnt=%0d err=%b expected 0 0 0", tag, out_valid, burst_left, cnt_err);
        end
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        foreach (m_buf[k]) m_buf[k] = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        check_reset("R12 after reset");

        // R8 R3 R1: row packet to row 3
        quad(hdr(ROWT, 5'd3, 6'h15), 32'h1111_0001, 32'h2222_0002, 32'h3333_0003, "R8 row packet");
        // R1: slots out of order
        wr(2, 32'hCCCC_0002, "R1"); wr(0, hdr(ROWT, 5'd14, 6'h3F), "R1");
        wr(1, 32'hBBBB_0001, "R1"); wr(3, 32'hDDDD_0003, "R1 out of order");
        // R2: only slots 0 and 3 written, 1 and 2 read as zero
        wr(0, hdr(ROWT, 5'd0, 6'h07), "R2"); wr(3, 32'h0BAD_F00D, "R2 cleared slots");
        idle(2);
        // R9: broadcast to a partial set of rows
        m_present = 15'h5A3C;
        quad(hdr(ROWT, 5'h1F, 6'h21), 32'hA, 32'hB, 32'hC, "R9 broadcast");
        // R10: absent row and nonexistent row code
        quad(hdr(ROWT, 5'd0, 6'h01), 32'h1, 32'h2, 32'h3, "R10 absent row");
        quad(hdr(ROWT, 5'd20, 6'h01), 32'h1, 32'h2, 32'h3, "R10 row code 20");
        m_present = '1;
        // R11: unknown type, local type with another register
        quad(hdr(8'h33, 5'd2, FREG), 32'h50, 32'h2, 32'h3, "R11 unknown type");
        quad(hdr(LOC, 5'd2, 6'h05), 32'h50, 32'h2, 32'h3, "R11 local other reg");
        // R6: load a count of 50 for row 7
        quad(hdr(LOC, 5'd7, FREG), 32'd50, 32'h0, 32'h0, "R6 load count");
        // R5: data quadwords bypass decoding, even with a row header in word 0
        quad(hdr(ROWT, 5'd1, 6'h09), 32'hF1, 32'hF2, 32'hF3, "R5 burst word");
        quad(32'hFFFF_FFFF, 32'h0, 32'h1234_5678, 32'h9, "R5 burst word 2");
        idle(2);
        // R12: reset mid-burst, with a stale slot
        wr(1, 32'hDEAD_BEEF, "R12 stale");
        @(posedge clk); #2; wr_en = 0; rst_n = 0;
        m_cnt = 0; foreach (m_buf[k]) m_buf[k] = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        check_reset("R12 reset mid-burst");
        wr(0, hdr(ROWT, 5'd4, 6'h02), "R12 slot cleared"); wr(3, 32'h4, "R12 slot cleared");
        idle(2);
        // R7: a count that is not a multiple of 25 still loads
        quad(hdr(LOC, 5'd9, FREG), 32'd2, 32'h0, 32'h0, "R7 odd count");
        // R4: decompress mode drops
        m_decomp = 1;
        quad(32'h1, 32'h2, 32'h3, 32'h4, "R4 dropped");
        quad(hdr(ROWT, 5'd1, 6'h01), 32'h2, 32'h3, 32'h4, "R4 dropped row pkt");
        m_decomp = 0;
        // R5 R13: finish the burst with back-to-back quadwords, then a row packet
        quad(32'hA0, 32'hA1, 32'hA2, 32'hA3, "R5 burst");
        quad(32'hB0, 32'hB1, 32'hB2, 32'hB3, "R5 burst last");
        quad(hdr(ROWT, 5'd6, 6'h11), 32'hC1, 32'hC2, 32'hC3, "R13 after burst");
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule